// File: doc/BRIEF.md
# Framed Synchronous Serial Transmitter

This block is the transmit half of a synchronous serial port. It shifts data words out on a single data pin, one bit per pulse of a bit-clock enable (`bit_tick`), and groups them into frames. A frame opens when a selectable start condition is seen: at once, or on a rising, falling or either edge of the frame-sync input. After an optional delay it can send a synchronization word held in its own register, and then a configured number of data words. The block can also drive a frame-sync output pulse whose length is set in the configuration.

Software loads data through a small register write port. One holding register is paired with the shift register. A ready flag tells software when the holding register may be written again. An empty flag shows that nothing remains to send. A sticky underrun flag records any data slot that found the holding register empty; that slot goes out at the idle level. Enable and disable are separate command bits, and disable wins when both arrive together. A disable that arrives mid-frame lets the current word finish and then ends the frame.

Top module: `fsx_tx`

## Requirements
- R1: After reset, `td` and `fs_out` are 0, `tx_ready` and `tx_empty` are 1, and `tx_enabled` and `tx_underrun` are 0.
- R2: Writes use `wr_addr` 0 = command, 1 = configuration, 2 = data holding register, 3 = sync word. The configuration fields are:
    - [3:0] word length minus one
    - [7:4] data words per frame minus one
    - [11:8] frame-sync length in bit ticks
    - [15:12] start delay
    - [17:16] start select
    - [18] MSB first
    - [19] sync word enable
    - [20] idle level

  A frame sends the sync word first when bit 19 is set, followed by the data words in the order they were written, one bit per tick.
- R3: With bit 18 set, each word leaves from bit (length-1) down to bit 0. With bit 18 clear, it leaves from bit 0 upward.
- R4: If the start event is seen on tick E and the start delay is d, the first frame bit appears on `td` after tick E+d+1.
- R5: Start select 0 starts on any tick. 1 starts on a tick where `fs_in` is high and was low at the previous tick. 2 starts on a high-to-low change. 3 starts on either change. A steady level on `fs_in` starts nothing.
- R6: Outside a frame's bits, `td` drives the idle level (bit 20).
- R7: Writing the data register clears `tx_ready`. `tx_ready` returns to 1 on the tick at which the word moves into the shift register.
- R8: `tx_empty` is 1 only when the holding register is empty and no sync or data word is being shifted.
- R9: Command bit 0 enables and command bit 1 disables. With both set, the block ends up disabled. `tx_enabled` shows the result one cycle later.
- R10: A disable during a frame lets the current word finish, ends the frame at that word boundary with `td` at the idle level, and leaves any waiting holding-register word untaken.
- R11: A data slot that finds the holding register empty is sent at the idle level and sets `tx_underrun`. `tx_underrun` stays set until a `stat_rd` pulse.
- R12: With frame-sync length L > 0, `fs_out` is high for L ticks, starting with the first bit of the frame. With L = 0 it stays low. `fs_out` changes only on ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle bit-clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 21 | Write data |
| stat_rd | input | 1 | Status read pulse; clears underrun |
| fs_in | input | 1 | Frame-sync input for start events |
| td | output | 1 | Serial data out |
| fs_out | output | 1 | Frame-sync pulse out |
| tx_ready | output | 1 | Holding register may be written |
| tx_empty | output | 1 | Nothing left to send |
| tx_enabled | output | 1 | Transmitter enabled |
| tx_underrun | output | 1 | Sticky underrun flag |

## Verification
A wrong bit counter or a wrong shift direction shows up as a bad bit on `td` within one word of the frame start. A slot counter that is off by one lengthens or shortens the frame, so the idle level appears one word too early or too late. A wrong start or delay counter moves every bit by whole ticks; because `td` is compared on every tick, the first misplaced bit is reported. Errors in the holding-register flags appear on `tx_ready` or `tx_empty` in the cycle after the transfer tick. They also appear as underrun slots that should not exist.

// File: rtl/fsx_pkg.sv
// fsx_pkg: shared types and register address/bit constants for the
// framed serial transmitter. Assumes a 2-bit register address space.
package fsx_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_WAIT  = 2'd1,
        ST_DELAY = 2'd2,
        ST_SHIFT = 2'd3
    } seq_state_t;

    typedef enum logic [1:0] {
        START_NOW  = 2'd0,
        START_RISE = 2'd1,
        START_FALL = 2'd2,
        START_ANY  = 2'd3
    } start_sel_t;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CFG  = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;
    localparam logic [1:0] ADDR_SYNC = 2'd3;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_DIS_BIT = 1;

endpackage

// File: rtl/fsx_regs.sv
// fsx_regs: software-visible state of the transmitter: configuration word,
// sync word, data holding register with its full flag, the enable bit and
// the sticky underrun flag.
// Assumes: BUS_W >= CFG_W, BUS_W >= DW, BUS_W >= 2.
module fsx_regs
    import fsx_pkg::*;
#(
    parameter int DW    = 16,
    parameter int CFG_W = 21,
    parameter int BUS_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [BUS_W-1:0] wr_data,
    input  logic             stat_rd,
    input  logic             take_data,
    input  logic             underrun_evt,
    output logic [CFG_W-1:0] cfg_q,
    output logic [DW-1:0]    sync_word,
    output logic [DW-1:0]    hold_word,
    output logic             hold_full,
    output logic             enabled,
    output logic             underrun
);

    logic wr_ctrl, wr_cfg, wr_data_reg, wr_sync;

    // Decode the write strobe per register.
    always_comb begin
        wr_ctrl     = wr_en && (wr_addr == ADDR_CTRL);
        wr_cfg      = wr_en && (wr_addr == ADDR_CFG);
        wr_data_reg = wr_en && (wr_addr == ADDR_DATA);
        wr_sync     = wr_en && (wr_addr == ADDR_SYNC);
    end

    // Enable bit: disable command takes priority over enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enabled <= 1'b0;
        end else if (wr_ctrl) begin
            if (wr_data[CTRL_DIS_BIT])
                enabled <= 1'b0;
            else if (wr_data[CTRL_EN_BIT])
                enabled <= 1'b1;
        end
    end

    // Configuration and sync word storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            sync_word <= '0;
        end else begin
            if (wr_cfg)
                cfg_q <= wr_data[CFG_W-1:0];
            if (wr_sync)
                sync_word <= wr_data[DW-1:0];
        end
    end

    // Holding register: a write fills it, a transfer to the shifter empties it;
    // a write in the same cycle as a transfer leaves the new word pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_word <= '0;
            hold_full <= 1'b0;
        end else if (wr_data_reg) begin
            hold_word <= wr_data[DW-1:0];
            hold_full <= 1'b1;
        end else if (take_data) begin
            hold_full <= 1'b0;
        end
    end

    // Sticky underrun flag: set by an empty data slot, cleared by status read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            underrun <= 1'b0;
        else if (underrun_evt)
            underrun <= 1'b1;
        else if (stat_rd)
            underrun <= 1'b0;
    end

endmodule

// File: rtl/fsx_start.sv
// fsx_start: frame start event detector. Samples the frame-sync input on
// every bit tick and flags the selected condition against the previous
// sample. The event is only meaningful in a cycle where bit_tick is high.
module fsx_start
    import fsx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_tick,
    input  logic       fs_in,
    input  logic [1:0] sel,
    output logic       start_evt
);

    logic fs_prev;

    // Remember the frame-sync level seen at the last tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fs_prev <= 1'b0;
        else if (bit_tick)
            fs_prev <= fs_in;
    end

    // Select the start condition.
    always_comb begin
        unique case (start_sel_t'(sel))
            START_NOW:  start_evt = 1'b1;
            START_RISE: start_evt = fs_in && !fs_prev;
            START_FALL: start_evt = !fs_in && fs_prev;
            START_ANY:  start_evt = fs_in ^ fs_prev;
            default:    start_evt = 1'b0;
        endcase
    end

endmodule

// File: rtl/fsx_seq.sv
// fsx_seq: frame sequencer, shift register and frame-sync generator.
// Waits for a start event, counts the start delay, then shifts an optional
// sync word and the configured number of data words, one bit per tick.
// Frame format is latched at the start event; the idle level outside a
// frame follows the live configuration.
// Assumes DW <= 2**LEN_W.
module fsx_seq
    import fsx_pkg::*;
#(
    parameter int DW    = 16,
    parameter int LEN_W = 4,
    parameter int NW_W  = 4,
    parameter int FSL_W = 4,
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             enabled,
    input  logic             start_evt,
    input  logic [LEN_W-1:0] wlen_m1,
    input  logic [NW_W-1:0]  nw_m1,
    input  logic [FSL_W-1:0] fslen,
    input  logic [DLY_W-1:0] dly,
    input  logic             msbf,
    input  logic             sync_en,
    input  logic             idle_lvl,
    input  logic [DW-1:0]    sync_word,
    input  logic [DW-1:0]    hold_word,
    input  logic             hold_full,
    output logic             take_data,
    output logic             underrun_evt,
    output logic             shifting,
    output logic             td,
    output logic             fs_out
);

    seq_state_t       state;
    logic [DLY_W-1:0] dly_cnt;
    logic [LEN_W-1:0] bit_cnt;
    logic [NW_W-1:0]  word_idx;
    logic [LEN_W-1:0] a_wlen;
    logic [NW_W-1:0]  a_nw;
    logic [FSL_W-1:0] a_fsl;
    logic [FSL_W-1:0] fs_rem;
    logic             a_msbf, a_sync, a_idle;
    logic             in_sync, gap, out_bit, fs_q;
    logic [DW-1:0]    shreg;

    logic             at_start, at_bound, last_slot, end_frame;
    logic             load, load_sync, load_data;
    logic [DW-1:0]    load_word;

    // Bit that leaves first from a word in the chosen order.
    function automatic logic pick_bit(input logic [DW-1:0] w, input logic m,
                                      input logic [LEN_W-1:0] l);
        return m ? w[l] : w[0];
    endfunction

    // Move the next bit into the pick position.
    function automatic logic [DW-1:0] step_word(input logic [DW-1:0] w, input logic m);
        return m ? (w << 1) : (w >> 1);
    endfunction

    // Frame events and the word selected for the next load.
    always_comb begin
        at_start     = bit_tick && (state == ST_DELAY) && (dly_cnt == '0) && enabled;
        at_bound     = bit_tick && (state == ST_SHIFT) && (bit_cnt == '0);
        last_slot    = !in_sync && (word_idx == a_nw);
        end_frame    = at_bound && (last_slot || !enabled);
        load         = at_start || (at_bound && !end_frame);
        load_sync    = at_start && a_sync;
        load_data    = load && !load_sync;
        take_data    = load_data && hold_full;
        underrun_evt = load_data && !hold_full;
        load_word    = load_sync ? sync_word : hold_word;
    end

    // Sequencer state, start delay count and frame-format latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_OFF;
            dly_cnt <= '0;
            a_wlen  <= '0;
            a_nw    <= '0;
            a_fsl   <= '0;
            a_msbf  <= 1'b0;
            a_sync  <= 1'b0;
            a_idle  <= 1'b0;
        end else begin
            unique case (state)
                ST_OFF, ST_WAIT: begin
                    if (!enabled) begin
                        state <= ST_OFF;
                    end else if (bit_tick && start_evt) begin
                        state   <= ST_DELAY;
                        dly_cnt <= dly;
                        a_wlen  <= wlen_m1;
                        a_nw    <= nw_m1;
                        a_fsl   <= fslen;
                        a_msbf  <= msbf;
                        a_sync  <= sync_en;
                        a_idle  <= idle_lvl;
                    end else begin
                        state <= ST_WAIT;
                    end
                end
                ST_DELAY: begin
                    if (!enabled)
                        state <= ST_OFF;
                    else if (at_start)
                        state <= ST_SHIFT;
                    else if (bit_tick)
                        dly_cnt <= dly_cnt - 1'b1;
                end
                ST_SHIFT: begin
                    if (end_frame)
                        state <= enabled ? ST_WAIT : ST_OFF;
                end
                default: state <= ST_OFF;
            endcase
        end
    end

    // Shift register, bit and word counters, empty-slot marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg    <= '0;
            out_bit  <= 1'b0;
            bit_cnt  <= '0;
            word_idx <= '0;
            in_sync  <= 1'b0;
            gap      <= 1'b0;
        end else if (load) begin
            shreg   <= step_word(load_word, a_msbf);
            out_bit <= pick_bit(load_word, a_msbf, a_wlen);
            bit_cnt <= a_wlen;
            gap     <= load_data && !hold_full;
            in_sync <= load_sync;
            if (at_start)
                word_idx <= '0;
            else if (!in_sync)
                word_idx <= word_idx + 1'b1;
        end else if (bit_tick && (state == ST_SHIFT) && (bit_cnt != '0)) begin
            shreg   <= step_word(shreg, a_msbf);
            out_bit <= pick_bit(shreg, a_msbf, a_wlen);
            bit_cnt <= bit_cnt - 1'b1;
        end
    end

    // Frame-sync pulse: armed at the first bit, counted down on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_q   <= 1'b0;
            fs_rem <= '0;
        end else if (at_start) begin
            fs_q   <= (a_fsl != '0);
            fs_rem <= a_fsl - 1'b1;
        end else if (bit_tick && fs_q) begin
            if (fs_rem == '0)
                fs_q <= 1'b0;
            else
                fs_rem <= fs_rem - 1'b1;
        end
    end

    // Output drive: data bit inside a filled slot, idle level otherwise.
    always_comb begin
        shifting = (state == ST_SHIFT) && !gap;
        if (shifting)
            td = out_bit;
        else if (state == ST_SHIFT)
            td = a_idle;
        else
            td = idle_lvl;
        fs_out = fs_q;
    end

endmodule

// File: rtl/fsx_tx.sv
// fsx_tx: top of the framed synchronous serial transmitter. Splits the
// configuration word into fields and connects the register block, the
// start detector and the frame sequencer.
// Assumes: one bit per bit_tick pulse; configuration is changed only
// while the transmitter is disabled or between frames.
module fsx_tx
    import fsx_pkg::*;
#(
    parameter int DW     = 16,
    parameter int NW_W   = 4,
    parameter int FSL_W  = 4,
    parameter int DLY_W  = 4,
    localparam int LEN_W = $clog2(DW),
    localparam int CFG_W = LEN_W + NW_W + FSL_W + DLY_W + 5,
    localparam int BUS_W = (CFG_W > DW) ? CFG_W : DW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [BUS_W-1:0] wr_data,
    input  logic             stat_rd,
    input  logic             fs_in,
    output logic             td,
    output logic             fs_out,
    output logic             tx_ready,
    output logic             tx_empty,
    output logic             tx_enabled,
    output logic             tx_underrun
);

    localparam int OFS_NW   = LEN_W;
    localparam int OFS_FSL  = OFS_NW + NW_W;
    localparam int OFS_DLY  = OFS_FSL + FSL_W;
    localparam int OFS_SEL  = OFS_DLY + DLY_W;
    localparam int OFS_MSBF = OFS_SEL + 2;
    localparam int OFS_SYNC = OFS_MSBF + 1;
    localparam int OFS_IDLE = OFS_SYNC + 1;

    logic [CFG_W-1:0] cfg_q;
    logic [DW-1:0]    sync_word, hold_word;
    logic             hold_full, take_data, underrun_evt, start_evt, shifting;

    fsx_regs #(.DW(DW), .CFG_W(CFG_W), .BUS_W(BUS_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .stat_rd      (stat_rd),
        .take_data    (take_data),
        .underrun_evt (underrun_evt),
        .cfg_q        (cfg_q),
        .sync_word    (sync_word),
        .hold_word    (hold_word),
        .hold_full    (hold_full),
        .enabled      (tx_enabled),
        .underrun     (tx_underrun)
    );

    fsx_start u_start (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .fs_in     (fs_in),
        .sel       (cfg_q[OFS_SEL +: 2]),
        .start_evt (start_evt)
    );

    fsx_seq #(
        .DW(DW), .LEN_W(LEN_W), .NW_W(NW_W), .FSL_W(FSL_W), .DLY_W(DLY_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_tick     (bit_tick),
        .enabled      (tx_enabled),
        .start_evt    (start_evt),
        .wlen_m1      (cfg_q[0 +: LEN_W]),
        .nw_m1        (cfg_q[OFS_NW +: NW_W]),
        .fslen        (cfg_q[OFS_FSL +: FSL_W]),
        .dly          (cfg_q[OFS_DLY +: DLY_W]),
        .msbf         (cfg_q[OFS_MSBF]),
        .sync_en      (cfg_q[OFS_SYNC]),
        .idle_lvl     (cfg_q[OFS_IDLE]),
        .sync_word    (sync_word),
        .hold_word    (hold_word),
        .hold_full    (hold_full),
        .take_data    (take_data),
        .underrun_evt (underrun_evt),
        .shifting     (shifting),
        .td           (td),
        .fs_out       (fs_out)
    );

    // Status flags seen by software.
    always_comb begin
        tx_ready = !hold_full;
        tx_empty = !hold_full && !shifting;
    end

endmodule

// File: rtl/fsx_tx_chk.sv
// fsx_tx_chk: protocol checks on the transmitter ports, bound to fsx_tx.
module fsx_tx_chk
    import fsx_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       bit_tick,
    input logic       wr_en,
    input logic [1:0] wr_addr,
    input logic [1:0] ctrl_bits,
    input logic       stat_rd,
    input logic       fs_out,
    input logic       tx_ready,
    input logic       tx_empty,
    input logic       tx_enabled,
    input logic       tx_underrun
);

    AST_WRITE_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_DATA) |=> !tx_ready); // R7

    AST_WRITE_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_DATA) |=> !tx_empty); // R8

    AST_DISABLE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_CTRL && ctrl_bits[CTRL_DIS_BIT]) |=> !tx_enabled); // R9

    AST_ENABLE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_CTRL && ctrl_bits[CTRL_EN_BIT] && !ctrl_bits[CTRL_DIS_BIT])
        |=> tx_enabled); // R9

    AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_underrun && !stat_rd) |=> tx_underrun); // R11

    AST_FS_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(fs_out)); // R12

endmodule

bind fsx_tx fsx_tx_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_tick    (bit_tick),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .ctrl_bits   (wr_data[1:0]),
    .stat_rd     (stat_rd),
    .fs_out      (fs_out),
    .tx_ready    (tx_ready),
    .tx_empty    (tx_empty),
    .tx_enabled  (tx_enabled),
    .tx_underrun (tx_underrun)
);

// File: tb/fsx_tx_tb.sv
module fsx_tx_tb;
    import fsx_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [20:0] wr_data = '0;
    logic        stat_rd = 1'b0;
    logic        fs_in = 1'b0;
    logic        td, fs_out, tx_ready, tx_empty, tx_enabled, tx_underrun;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    fsx_tx u_dut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .stat_rd(stat_rd), .fs_in(fs_in),
        .td(td), .fs_out(fs_out), .tx_ready(tx_ready), .tx_empty(tx_empty),
        .tx_enabled(tx_enabled), .tx_underrun(tx_underrun)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: drive inputs at the falling edge, return after the next falling edge.
    task automatic cyc(input logic tk, input logic we, input logic [1:0] a,
                       input logic [20:0] d, input logic rd);
        bit_tick = tk; wr_en = we; wr_addr = a; wr_data = d; stat_rd = rd;
        @(posedge clk);
        @(negedge clk);
        bit_tick = 1'b0; wr_en = 1'b0; stat_rd = 1'b0;
    endtask

    task automatic tk();
        cyc(1'b1, 1'b0, 2'd0, '0, 1'b0);
    endtask

    task automatic sp();
        cyc(1'b0, 1'b0, 2'd0, '0, 1'b0);
    endtask

    task automatic wr(input logic [1:0] a, input logic [20:0] d);
        cyc(1'b0, 1'b1, a, d, 1'b0);
    endtask

    function automatic logic [20:0] cfgw(input int wl, input int nw, input int fsl,
                                         input int dl, input int sel, input int m,
                                         input int sy, input int id);
        logic [20:0] v;
        v = '0;
        v[3:0]   = 4'(wl);
        v[7:4]   = 4'(nw);
        v[11:8]  = 4'(fsl);
        v[15:12] = 4'(dl);
        v[17:16] = 2'(sel);
        v[18]    = 1'(m);
        v[19]    = 1'(sy);
        v[20]    = 1'(id);
        return v;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1 (run completed)");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [3:0] pat;
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 td", td, 0);
        chk("R1 fs_out", fs_out, 0);
        chk("R1 ready", tx_ready, 1);
        chk("R1 empty", tx_empty, 1);
        chk("R1 enabled", tx_enabled, 0);
        chk("R1 underrun", tx_underrun, 0);

        // R5 rising-edge start, delay 1, MSB first, fs length 3, idle 1
        wr(ADDR_CFG, cfgw(3, 0, 3, 1, 1, 1, 0, 1));
        wr(ADDR_DATA, 21'h0000A);
        wr(ADDR_CTRL, 21'd1);
        chk("R9 enable", tx_enabled, 1);
        for (int i = 0; i < 3; i++) begin
            tk(); chk("R5 no start while low", td, 1); sp();
        end
        fs_in = 1'b1;
        tk(); chk("R4 event tick idle", td, 1); sp();
        tk(); chk("R4 delay tick idle", td, 1); chk("R12 fs before", fs_out, 0); sp();
        pat = 4'b1010;
        for (int b = 0; b < 4; b++) begin
            tk();
            chk("R3 msb first bit", td, pat[3-b]);
            chk("R12 fs pulse", fs_out, (b < 3) ? 1 : 0);
            sp();
        end
        tk(); chk("R6 idle after frame", td, 1); chk("R12 fs low", fs_out, 0); sp();
        for (int i = 0; i < 3; i++) begin
            tk(); chk("R5 steady high no start", td, 1);
            chk("R5 no frame started", tx_underrun, 0); sp();
        end
        wr(ADDR_CTRL, 21'd2);

        // R5 falling-edge start, no delay, LSB first, idle 0
        wr(ADDR_CFG, cfgw(3, 0, 0, 0, 2, 0, 0, 0));
        wr(ADDR_DATA, 21'h00005);
        wr(ADDR_CTRL, 21'd1);
        tk(); chk("R5 high level no start", td, 0); sp();
        fs_in = 1'b0;
        tk(); chk("R4 fall event tick idle", td, 0); sp();
        pat = 4'b0101;
        for (int b = 0; b < 4; b++) begin
            tk(); chk("R3 lsb first bit", td, pat[b]); sp();
        end
        tk(); chk("R6 idle 0 after frame", td, 0); sp();
        wr(ADDR_CTRL, 21'd2);

        // R9 both command bits set: disable wins
        wr(ADDR_CTRL, 21'd3);
        chk("R9 disable priority", tx_enabled, 0);

        // R11 underrun: two words, only one written, idle 1
        wr(ADDR_CFG, cfgw(3, 1, 0, 0, 0, 1, 0, 1));
        wr(ADDR_DATA, 21'h00009);
        wr(ADDR_CTRL, 21'd1);
        tk(); sp();
        pat = 4'b1001;
        for (int b = 0; b < 4; b++) begin
            tk(); chk("R2 first word bit", td, pat[3-b]);
            if (b == 1) chk("R8 busy not empty", tx_empty, 0);
            sp();
        end
        for (int b = 0; b < 4; b++) begin
            tk(); chk("R11 empty slot idle", td, 1);
            if (b == 0) chk("R11 underrun set", tx_underrun, 1);
            if (b == 1) chk("R8 empty during gap", tx_empty, 1);
            sp();
        end
        chk("R11 sticky", tx_underrun, 1);
        cyc(1'b0, 1'b0, 2'd0, '0, 1'b1);
        chk("R11 cleared by read", tx_underrun, 0);
        tk(); chk("R11 stays clear", tx_underrun, 0); sp();
        wr(ADDR_CTRL, 21'd2);

        // R10 disable mid-frame ends at the word boundary
        wr(ADDR_CFG, cfgw(3, 2, 0, 0, 0, 1, 0, 0));
        wr(ADDR_DATA, 21'h0000F);
        wr(ADDR_CTRL, 21'd1);
        tk(); chk("R6 idle before", td, 0); sp();
        tk(); chk("R2 bit0", td, 1); chk("R7 ready after load", tx_ready, 1);
        wr(ADDR_DATA, 21'h0000F);
        chk("R7 ready cleared", tx_ready, 0);
        tk(); chk("R2 bit1", td, 1);
        wr(ADDR_CTRL, 21'd2);
        chk("R9 disabled", tx_enabled, 0);
        tk(); chk("R10 word continues", td, 1); sp();
        tk(); chk("R10 word finishes", td, 1); sp();
        tk(); chk("R10 idle at boundary", td, 0);
        chk("R10 next word not taken", tx_ready, 0); sp();
        tk(); chk("R10 stays idle", td, 0); sp();

        // Sweep: immediate start over word length, words, order, sync, delay, idle
        k = 0;
        for (int wi = 0; wi < 3; wi++)
        for (int nw = 0; nw < 3; nw++)
        for (int m = 0; m < 2; m++)
        for (int sy = 0; sy < 2; sy++)
        for (int di = 0; di < 2; di++)
        for (int id = 0; id < 2; id++) begin
            int wl, w, total, fsl, dl, f, nxt;
            logic [15:0] words [3];
            logic [15:0] syncw;
            wl = (wi == 0) ? 0 : ((wi == 1) ? 3 : 7);
            w = wl + 1;
            dl = di * 2;
            fsl = k % 3;
            total = (nw + 1 + sy) * w;
            f = dl + 2;
            for (int i = 0; i < 3; i++) words[i] = 16'(k * 37 + i * 113 + 5);
            syncw = 16'hA5C3 ^ 16'(k);
            wr(ADDR_CFG, cfgw(wl, nw, fsl, dl, 0, m, sy, id));
            wr(ADDR_SYNC, {5'd0, syncw});
            wr(ADDR_DATA, {5'd0, words[0]});
            chk("R7 ready low after write", tx_ready, 0);
            chk("R8 not empty with word held", tx_empty, 0);
            nxt = 1;
            wr(ADDR_CTRL, 21'd1);
            for (int t = 1; t <= f + total; t++) begin
                int p, slot, b;
                logic [15:0] word;
                logic e, fe;
                tk();
                p = t - f;
                if (p >= 0 && p < total) begin
                    slot = p / w;
                    b = p % w;
                    word = (sy == 1 && slot == 0) ? syncw : words[slot - sy];
                    e = (m == 1) ? word[w - 1 - b] : word[b];
                    chk("R2 R3 R4 frame bit", td, e);
                end else begin
                    chk("R4 R6 idle level", td, id);
                end
                fe = (fsl != 0) && (t >= f) && (t < f + fsl);
                chk("R12 frame sync", fs_out, fe);
                if (tx_ready && nxt <= nw) begin
                    wr(ADDR_DATA, {5'd0, words[nxt]});
                    nxt++;
                end else begin
                    sp();
                end
            end
            chk("R11 no underrun when fed", tx_underrun, 0);
            wr(ADDR_CTRL, 21'd2);
            chk("R8 empty after frame", tx_empty, 1);
            chk("R9 disabled after command", tx_enabled, 0);
            k++;
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule